// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bit Decoder

This block receives a single-wire serial stream in which each bit is carried by the length of one high pulse. There is no separate clock line. A short high pulse stands for a zero and a long high pulse stands for a one. Between pulses the line must stay low for a minimum gap. When nothing drives the line it rests low, and a low line is treated as idle.

The input is assumed to be already digital. It first passes through a synchronizer. After that, a saturating counter clocked by the system clock measures how long each pulse stays high, and a second counter measures the low gap before the next pulse. A bit is resolved on the falling edge of its pulse. The block then issues a bit-valid strobe with the decoded value. A falling-edge strobe is also issued for downstream shift logic. Pulses of ambiguous length raise a one-cycle width error. Pulses that start before the gap has elapsed raise a one-cycle gap error. All limits are parameters counted in clock cycles.

A four-state controller sequences the work:
- `ST_READY`: the line is low and the gap has been met.
- `ST_GAP`: the line is low and the gap is still running.
- `ST_HIGH`: a legal pulse is being measured.
- `ST_ORPHAN`: a pulse that started too early is being waited out.

The transitions are:
- READY→HIGH on a high level.
- GAP→READY when the low count reaches the minimum gap.
- GAP→ORPHAN on a high level before that point.
- HIGH→GAP on a low level (bit decode).
- ORPHAN→GAP on a low level.

Top module: `pulse_bit_rx`

## Requirements
- R1: A synchronous active-high reset clears every output to 0 and enters `ST_READY`, so the first pulse after reset is accepted without any gap requirement.
- R2: A pulse high for W cycles with ZERO_MIN_CYC ≤ W ≤ ZERO_MAX_CYC yields one `bit_vld` strobe with `bit_val` = 0. Both boundaries are included.
- R3: A pulse with W ≥ ONE_MIN_CYC yields one `bit_vld` strobe with `bit_val` = 1. The width counter saturates, so a pulse far longer than its range still decodes as 1.
- R4: A pulse with ZERO_MAX_CYC < W < ONE_MIN_CYC yields one `width_err` strobe and no bit.
- R5: A pulse with W < ZERO_MIN_CYC yields one `width_err` strobe and no bit.
- R6: A pulse whose preceding low gap is shorter than GAP_MIN_CYC cycles raises a one-cycle `gap_err` when it starts. It yields neither a bit nor a width error. The next gap is measured from that pulse's falling edge.
- R7: A low gap of exactly GAP_MIN_CYC cycles is legal.
- R8: `fall_stb` pulses for one cycle on every falling edge of the synchronized line, including discarded pulses. `bit_vld` and `width_err` always coincide with it.
- R9: While the line rests low, no strobe of any kind is produced.
- R10: In any cycle at most one of `bit_vld`, `width_err` and `gap_err` is high. `bit_val` is high only together with `bit_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all widths are counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Digital single-wire line, idle low |
| bit_vld | output | 1 | One-cycle strobe: a bit was decoded |
| bit_val | output | 1 | Decoded bit value, valid with `bit_vld` |
| fall_stb | output | 1 | One-cycle strobe on each falling edge of the synchronized line |
| width_err | output | 1 | One-cycle strobe: pulse width in neither the zero nor the one window |
| gap_err | output | 1 | One-cycle strobe: pulse started before the minimum low gap |

## Verification
The in-line assertions watch several properties on every cycle:
- the exclusivity of the three result strobes;
- the pairing of `bit_vld` and `width_err` with `fall_stb`;
- the `bit_val` gating;
- the single-cycle shape of `gap_err`;
- quiet outputs right after reset;
- the counter holding at its ceiling.

Whether a given width decodes to the right class, and whether the gap rule is applied at the correct count, can only be shown by the bench's scenarios. These drive pulses at each window boundary and one cycle either side of it. They also cover a saturating long pulse, short gaps, and a legal gap that follows a discarded pulse.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_GAP    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_ORPHAN = 2'd3
    } pbr_state_e;

    typedef enum logic [1:0] {
        CLS_SHORT = 2'd0,
        CLS_ZERO  = 2'd1,
        CLS_MID   = 2'd2,
        CLS_ONE   = 2'd3
    } pbr_class_e;

endpackage

// File: rtl/pbr_sync.sv
module pbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic fell
);
    logic [STAGES-1:0] chain;
    logic              lvl_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign fell = lvl_q & ~lvl;

endmodule

// File: rtl/pbr_satcnt.sv
module pbr_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load1,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (load1)               cnt <= ONE;
        else if (inc && cnt != MAXV)  cnt <= cnt + ONE;
    end

    // R3: a counter at its ceiling stays there while still counting
    a_r3_saturates: assert property (@(posedge clk) disable iff (rst)
        (inc && !load1 && cnt == MAXV) |=> (cnt == MAXV));

endmodule

// File: rtl/pbr_classify.sv
module pbr_classify
    import pbr_pkg::*;
#(
    parameter int W        = 8,
    parameter int ZERO_MIN = 3,
    parameter int ZERO_MAX = 20,
    parameter int ONE_MIN  = 60
) (
    input  logic [W-1:0] width,
    output pbr_class_e   cls
);
    localparam logic [W-1:0] ZMIN_L = W'(ZERO_MIN);
    localparam logic [W-1:0] ZMAX_L = W'(ZERO_MAX);
    localparam logic [W-1:0] OMIN_L = W'(ONE_MIN);

    always_comb begin
        if (width < ZMIN_L)       cls = CLS_SHORT;
        else if (width <= ZMAX_L) cls = CLS_ZERO;
        else if (width < OMIN_L)  cls = CLS_MID;
        else                      cls = CLS_ONE;
    end

endmodule

// File: rtl/pulse_bit_rx.sv
module pulse_bit_rx
    import pbr_pkg::*;
#(
    parameter int ZERO_MIN_CYC = 13,
    parameter int ZERO_MAX_CYC = 2500,
    parameter int ONE_MIN_CYC  = 12500,
    parameter int GAP_MIN_CYC  = 2500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic bit_vld,
    output logic bit_val,
    output logic fall_stb,
    output logic width_err,
    output logic gap_err
);
    localparam int HW = $clog2(ONE_MIN_CYC + 1);
    localparam int GW = $clog2(GAP_MIN_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_MIN_CYC - 1);

    logic          lvl;
    logic          fell;
    logic [HW-1:0] hi_cnt;
    logic [GW-1:0] lo_cnt;
    logic          hi_load, hi_inc, lo_load, lo_inc;
    pbr_class_e    cls;
    pbr_state_e    st, st_nxt;
    logic          decode_now;

    pbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .din (line_in), .lvl (lvl), .fell (fell)
    );

    pbr_satcnt #(.W(HW)) u_hi_cnt (
        .clk (clk), .rst (rst), .load1 (hi_load), .inc (hi_inc), .cnt (hi_cnt)
    );

    pbr_satcnt #(.W(GW)) u_lo_cnt (
        .clk (clk), .rst (rst), .load1 (lo_load), .inc (lo_inc), .cnt (lo_cnt)
    );

    pbr_classify #(
        .W (HW), .ZERO_MIN (ZERO_MIN_CYC), .ZERO_MAX (ZERO_MAX_CYC), .ONE_MIN (ONE_MIN_CYC)
    ) u_cls (
        .width (hi_cnt), .cls (cls)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_READY;
        else     st <= st_nxt;
    end

    // next state and counter control
    always_comb begin
        st_nxt  = st;
        hi_load = 1'b0;
        hi_inc  = 1'b0;
        lo_load = 1'b0;
        lo_inc  = 1'b0;
        unique case (st)
            ST_READY: begin
                if (lvl) begin
                    st_nxt  = ST_HIGH;
                    hi_load = 1'b1;
                end
            end
            ST_GAP: begin
                if (lvl)                    st_nxt = ST_ORPHAN;
                else if (lo_cnt == GAP_LAST) st_nxt = ST_READY;
                else                        lo_inc = 1'b1;
            end
            ST_HIGH: begin
                if (lvl) begin
                    hi_inc = 1'b1;
                end else begin
                    st_nxt  = ST_GAP;
                    lo_load = 1'b1;
                end
            end
            ST_ORPHAN: begin
                if (!lvl) begin
                    st_nxt  = ST_GAP;
                    lo_load = 1'b1;
                end
            end
        endcase
    end

    assign decode_now = (st == ST_HIGH) && !lvl;

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_vld   <= 1'b0;
            bit_val   <= 1'b0;
            fall_stb  <= 1'b0;
            width_err <= 1'b0;
            gap_err   <= 1'b0;
        end else begin
            fall_stb  <= fell;
            bit_vld   <= decode_now && (cls == CLS_ZERO || cls == CLS_ONE);
            bit_val   <= decode_now && (cls == CLS_ONE);
            width_err <= decode_now && (cls == CLS_SHORT || cls == CLS_MID);
            gap_err   <= (st == ST_GAP) && lvl;
        end
    end

    // R10: result strobes are mutually exclusive
    a_r10_one_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bit_vld, width_err, gap_err}));

    // R10: value only qualified by valid
    a_r10_val_gated: assert property (@(posedge clk) disable iff (rst)
        bit_val |-> bit_vld);

    // R8: decode results land with the falling-edge strobe
    a_r8_result_on_fall: assert property (@(posedge clk) disable iff (rst)
        (bit_vld || width_err) |-> fall_stb);

    // R6: gap error lasts exactly one cycle
    a_r6_gap_single: assert property (@(posedge clk) disable iff (rst)
        gap_err |=> !gap_err);

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(bit_vld || width_err || gap_err || fall_stb));

endmodule

// File: tb/pulse_bit_rx_bench.sv
module pulse_bit_rx_bench;
    localparam int ZMIN = 3;
    localparam int ZMAX = 20;
    localparam int OMIN = 60;
    localparam int GAPM = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;
    logic bit_vld, bit_val, fall_stb, width_err, gap_err;

    always #2 clk = ~clk;

    pulse_bit_rx #(
        .ZERO_MIN_CYC (ZMIN), .ZERO_MAX_CYC (ZMAX),
        .ONE_MIN_CYC (OMIN), .GAP_MIN_CYC (GAPM), .SYNC_STAGES (2)
    ) u_pulse_bit_rx (
        .clk (clk), .rst (rst), .line_in (line_in),
        .bit_vld (bit_vld), .bit_val (bit_val), .fall_stb (fall_stb),
        .width_err (width_err), .gap_err (gap_err)
    );

    // codes: 0 bit zero, 1 bit one, 2 width error, 3 gap error
    int    exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    fall_seen = 0;
    int    fall_exp = 0;
    bit    have_prev = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int gap, input int width, input string req);
        int code;
        if (have_prev && gap < GAPM) code = 3;
        else if (width < ZMIN)       code = 2;
        else if (width <= ZMAX)      code = 0;
        else if (width < OMIN)       code = 2;
        else                         code = 1;
        exp_q.push_back(code);
        tag_q.push_back(req);
        repeat (gap) @(posedge clk);
        #1 line_in = 1'b1;
        repeat (width) @(posedge clk);
        #1 line_in = 1'b0;
        have_prev = 1'b1;
        fall_exp++;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            int hot;
            int code;
            hot = int'(bit_vld) + int'(width_err) + int'(gap_err);
            if (fall_stb) fall_seen++;
            if (hot != 0) begin
                check(hot == 1, "R10 strobe count", hot, 1);
                check(!(bit_val && !bit_vld), "R10 bit_val gating", int'(bit_val), 0);
                code = gap_err ? 3 : (width_err ? 2 : (bit_val ? 1 : 0));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected strobe", code, -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(code == e, t, code, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({bit_vld, bit_val, fall_stb, width_err, gap_err} == 5'b0,
              "R1 reset outputs", int'({bit_vld, bit_val, fall_stb, width_err, gap_err}), 0);
        @(posedge clk);
        #1 rst = 1'b0;

        send(5,  10,  "R1 first pulse no gap needed");
        send(20, 3,   "R7 exact gap, R2 zero at min width");
        send(25, 20,  "R2 zero at max width");
        send(20, 60,  "R3 one at min width");
        send(30, 200, "R3 one with saturated counter");
        send(20, 21,  "R4 width just above zero window");
        send(20, 59,  "R4 width just below one window");
        send(20, 2,   "R5 width below zero minimum");
        send(19, 10,  "R6 gap one cycle short");
        send(20, 10,  "R6 gap restarts after discarded pulse");
        send(5,  70,  "R6 long pulse after short gap");
        send(40, 1,   "R5 single cycle pulse");
        send(21, 65,  "R3 one after long gap");

        repeat (40) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R9 all pulses resolved", exp_q.size(), 0);
        check(fall_seen == fall_exp, "R8 falling strobes", fall_seen, fall_exp);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule